// File: doc/BRIEF.md
# Host Data Port Handshake Latch

This block holds one data word between a host I/O data port and a remote DMA engine that moves data to and from buffer RAM. Software starts an operation by giving a direction and a word count. In the read direction the DMA side fills the latch from RAM. The host then takes the word with a read strobe, and that strobe also acknowledges the DMA so that it may supply the next word. A host read that reaches an empty latch is stalled with a wait line until the word lands.

In the write direction the roles are reversed. The host places a word with a write strobe and the DMA side drains it toward RAM. A host write that meets a latch still holding the previous word is stalled with wait until the drain happens. The operation ends on its own once the requested number of words has passed through the latch. While no operation runs, the port ignores host strobes and never stalls the host.

Both host strobes are level signals. One access completes in every cycle where the strobe is high and wait is low. The DMA side uses a valid/ready pair, and a word moves in any cycle where both are high.

Top module: `hdp_port_latch`

## Requirements
- R1: After reset the block is idle: `op_busy_o`, `host_wait_o`, `fill_ready_o` and `drain_valid_o` are 0 and `host_rdata_o` is 0.
- R2: A cycle with `op_start_i` high while idle and `op_words_i` non-zero makes `op_busy_o` 1 from the next cycle on, with the direction taken from `op_dir_i` (0 = host reads, 1 = host writes). A start with a zero count, or a start while busy, has no effect.
- R3: In read direction, `fill_ready_o` is 1 while the latch is empty and words remain. An accepted fill word appears on `host_rdata_o` from the next cycle on, and `fill_ready_o` then drops while that word is unread.
- R4: In read direction, a host read of an empty latch raises `host_wait_o` in the same cycle. Wait falls in the cycle after a fill word is accepted.
- R5: In read direction, a host read of a full latch completes without wait and returns the held word. In that same cycle `fill_ready_o` is 1 if further words remain, so the latch can be refilled without a gap.
- R6: In write direction, a host write to an empty latch completes without wait. From the next cycle `drain_valid_o` is 1 with the written word on `drain_data_o`.
- R7: In write direction, a host write to a full latch raises `host_wait_o` unless the DMA drains the latch in that same cycle. A stalled write is not captured.
- R8: An operation of N words ends after exactly N host reads (read direction) or N drains (write direction). `op_busy_o` falls in the cycle after the last one, and no fill is offered beyond N words.
- R9: While idle, host strobes never raise `host_wait_o`, a host write leaves the latch unchanged, `host_rdata_o` keeps its last value, and `fill_ready_o` and `drain_valid_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start_i | input | 1 | Start pulse for a transfer operation |
| op_dir_i | input | 1 | Direction: 0 host reads, 1 host writes |
| op_words_i | input | CNT_W | Number of words in the operation |
| op_busy_o | output | 1 | Operation in progress |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Latch contents seen by the host |
| host_wait_o | output | 1 | Stall toward the host |
| fill_valid_i | input | 1 | DMA offers a word (read direction) |
| fill_data_i | input | DATA_W | DMA fill word |
| fill_ready_o | output | 1 | Latch accepts a fill word |
| drain_valid_o | output | 1 | Latch holds a word for the DMA (write direction) |
| drain_data_o | output | DATA_W | Word handed to the DMA |
| drain_ready_i | input | 1 | DMA takes the word |

## Verification
The main function is swept over every word count from 1 to 4 in both directions. In each case the DMA side and the host side each insert a fixed delay of 0, 1 or 2 cycles before every access. When the DMA is faster, the latch is full most of the time, which tests the same-cycle refill and drain paths. When the host is faster, the wait stall is exercised on nearly every word. Equal delays mix the two cases. Every word seen by the host or the DMA is compared with an arithmetic sequence, and the operation must end exactly at its count. Directed cases cover ignored starts, idle strobes and the cycle in which each output first changes.

// File: rtl/hdp_pkg.sv
// Package: shared types for the host data port latch.
// Assumes: nothing beyond IEEE 1800-2017.
package hdp_pkg;
    typedef enum logic {
        HDP_DIR_RD = 1'b0,
        HDP_DIR_WR = 1'b1
    } hdp_dir_e;
endpackage

// File: rtl/hdp_op_ctrl.sv
// Module: operation controller. Tracks whether a transfer is running, in
// which direction, and how many words remain to complete.
// Assumes: done_i is pulsed once per completed word, and only while busy.
module hdp_op_ctrl
    import hdp_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [CNT_W-1:0] words_i,
    input  logic             done_i,
    output logic             busy_o,
    output hdp_dir_e         dir_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;
    logic             busy_q;
    hdp_dir_e         dir_q;

    // Purpose: load a new operation when idle, count completions down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            dir_q  <= HDP_DIR_RD;
        end else if (start_i && !busy_q && (words_i != '0)) begin
            busy_q <= 1'b1;
            rem_q  <= words_i;
            dir_q  <= hdp_dir_e'(dir_i);
        end else if (done_i) begin
            rem_q <= rem_q - ONE;
            if (rem_q == ONE) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy_o = busy_q;
    assign dir_o  = dir_q;
    assign last_o = (rem_q == ONE);

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> busy_q);
    assert_count_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q != '0));
endmodule

// File: rtl/hdp_word_latch.sv
// Module: single-word holding register with an occupancy flag.
// Assumes: load and unload may coincide; the load then wins and the flag
// stays set with the new word.
module hdp_word_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              unload_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Purpose: capture a word on load, clear occupancy on unload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (load_i) begin
            full_q <= 1'b1;
            data_q <= load_data_i;
        end else if (unload_i) begin
            full_q <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!full_q || unload_i));
    assert_no_empty_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        unload_i |-> full_q);
    assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(data_q));
endmodule

// File: rtl/hdp_flow_ctl.sv
// Module: combinational handshake logic. Turns host strobes and DMA
// valid/ready into latch load/unload, completion pulses and host wait.
// Assumes: host strobes are levels; an access completes when strobe is
// high and wait is low.
module hdp_flow_ctl
    import hdp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              busy_i,
    input  hdp_dir_e          dir_i,
    input  logic              full_i,
    input  logic              last_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic              fill_valid_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic              drain_ready_i,
    output logic              load_o,
    output logic [DATA_W-1:0] load_data_o,
    output logic              unload_o,
    output logic              done_o,
    output logic              host_wait_o,
    output logic              fill_ready_o,
    output logic              drain_valid_o
);
    logic rd_mode, wr_mode;
    logic host_take, host_put;
    logic fill_fire, drain_fire;

    // Purpose: derive every handshake from mode, occupancy and strobes.
    always_comb begin
        rd_mode       = busy_i && (dir_i == HDP_DIR_RD);
        wr_mode       = busy_i && (dir_i == HDP_DIR_WR);
        host_take     = rd_mode && host_rd_i && full_i;
        fill_ready_o  = rd_mode && (!full_i || (host_take && !last_i));
        fill_fire     = fill_valid_i && fill_ready_o;
        drain_valid_o = wr_mode && full_i;
        drain_fire    = drain_valid_o && drain_ready_i;
        host_put      = wr_mode && host_wr_i && (!full_i || (drain_fire && !last_i));
        host_wait_o   = (rd_mode && host_rd_i && !full_i)
                      || (wr_mode && host_wr_i && full_i && !drain_fire);
        load_o        = fill_fire || host_put;
        load_data_o   = rd_mode ? fill_data_i : host_wdata_i;
        unload_o      = host_take || drain_fire;
        done_o        = unload_o;
    end

    always_comb begin
        assert_idle_quiet_R9: assert (busy_i || !(host_wait_o || fill_ready_o || drain_valid_o));
    end
endmodule

// File: rtl/hdp_port_latch.sv
// Module: top of the host data port handshake latch.
// Assumes: one operation at a time; the DMA obeys valid/ready.
module hdp_port_latch
    import hdp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  logic              op_dir_i,
    input  logic [CNT_W-1:0]  op_words_i,
    output logic              op_busy_o,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              host_wait_o,
    input  logic              fill_valid_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic              fill_ready_o,
    output logic              drain_valid_o,
    output logic [DATA_W-1:0] drain_data_o,
    input  logic              drain_ready_i
);
    logic              busy, last, full, load, unload, done;
    hdp_dir_e          dir;
    logic [DATA_W-1:0] load_data, latch_data;

    hdp_op_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (op_start_i),
        .dir_i   (op_dir_i),
        .words_i (op_words_i),
        .done_i  (done),
        .busy_o  (busy),
        .dir_o   (dir),
        .last_o  (last)
    );

    hdp_word_latch #(.DATA_W(DATA_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_data_i (load_data),
        .unload_i    (unload),
        .full_o      (full),
        .data_o      (latch_data)
    );

    hdp_flow_ctl #(.DATA_W(DATA_W)) u_flow (
        .busy_i        (busy),
        .dir_i         (dir),
        .full_i        (full),
        .last_i        (last),
        .host_rd_i     (host_rd_i),
        .host_wr_i     (host_wr_i),
        .host_wdata_i  (host_wdata_i),
        .fill_valid_i  (fill_valid_i),
        .fill_data_i   (fill_data_i),
        .drain_ready_i (drain_ready_i),
        .load_o        (load),
        .load_data_o   (load_data),
        .unload_o      (unload),
        .done_o        (done),
        .host_wait_o   (host_wait_o),
        .fill_ready_o  (fill_ready_o),
        .drain_valid_o (drain_valid_o)
    );

    assign op_busy_o    = busy;
    assign host_rdata_o = latch_data;
    assign drain_data_o = latch_data;

    assert_wait_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dir == HDP_DIR_RD && host_rd_i && $past(fill_valid_i && fill_ready_o))
        |-> !host_wait_o);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start_i && !busy && op_words_i != '0) |=> op_busy_o);
endmodule

// File: tb/tb_hdp_port_latch.sv
module tb_hdp_port_latch;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_start, op_dir;
    logic [CW-1:0] op_words;
    logic          busy, host_rd, host_wr, host_wait;
    logic [DW-1:0] host_wdata, host_rdata, fill_data, drain_data;
    logic          fill_valid, fill_ready, drain_valid, drain_ready;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    hdp_port_latch #(.DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .op_start_i(op_start), .op_dir_i(op_dir), .op_words_i(op_words),
        .op_busy_o(busy),
        .host_rd_i(host_rd), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
        .host_rdata_o(host_rdata), .host_wait_o(host_wait),
        .fill_valid_i(fill_valid), .fill_data_i(fill_data), .fill_ready_o(fill_ready),
        .drain_valid_o(drain_valid), .drain_data_o(drain_data), .drain_ready_i(drain_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_start = 0; op_dir = 0; op_words = '0;
        host_rd = 0; host_wr = 0; host_wdata = '0;
        fill_valid = 0; fill_data = '0; drain_ready = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start_op(input bit dir, input int n);
        op_start = 1; op_dir = dir; op_words = CW'(n);
        @(negedge clk);
        op_start = 0;
    endtask

    task automatic run_rd(input int n, input int d, input int h, input int base);
        start_op(1'b0, n);
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    repeat (d) @(negedge clk);
                    fill_valid = 1; fill_data = DW'(base + i);
                    forever begin
                        #1;
                        if (fill_ready) break;
                        @(negedge clk);
                    end
                    @(negedge clk);
                    fill_valid = 0;
                end
            end
            begin
                for (int i = 0; i < n; i++) begin
                    bit first = 1'b1;
                    repeat (h) @(negedge clk);
                    host_rd = 1;
                    forever begin
                        #1;
                        if (first && i == 0 && h == 0)
                            chk(host_wait == 1'b1, "R4 wait on empty read", int'(host_wait), 1);
                        first = 1'b0;
                        if (!host_wait) begin
                            chk(host_rdata == DW'(base + i), "R5 read word", int'(host_rdata), (base + i) % 256);
                            break;
                        end
                        @(negedge clk);
                    end
                    @(negedge clk);
                    host_rd = 0;
                end
            end
        join
        #1;
        chk(!busy, "R8 read op end", int'(busy), 0);
        chk(!fill_ready, "R8 no extra fill", int'(fill_ready), 0);
        @(negedge clk);
    endtask

    task automatic run_wr(input int n, input int d, input int h, input int base);
        int waits = 0;
        start_op(1'b1, n);
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    repeat (h) @(negedge clk);
                    host_wr = 1; host_wdata = DW'(base + i);
                    forever begin
                        #1;
                        if (!host_wait) break;
                        waits++;
                        @(negedge clk);
                    end
                    @(negedge clk);
                    host_wr = 0;
                end
            end
            begin
                int got = 0;
                int seen = 0;
                while (got < n) begin
                    drain_ready = drain_valid && (seen >= d);
                    #1;
                    if (drain_valid && drain_ready) begin
                        chk(drain_data == DW'(base + got), "R6 drained word", int'(drain_data), (base + got) % 256);
                        got++;
                        seen = 0;
                    end else if (drain_valid) begin
                        seen++;
                    end
                    @(negedge clk);
                end
                drain_ready = 0;
            end
        join
        #1;
        chk(!busy, "R8 write op end", int'(busy), 0);
        if (d >= 1 && h == 0 && n >= 2)
            chk(waits > 0, "R7 write stalled while full", waits, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        chk(!busy && !host_wait && !fill_ready && !drain_valid, "R1 idle after reset",
            int'({busy, host_wait, fill_ready, drain_valid}), 0);
        chk(host_rdata == '0, "R1 rdata after reset", int'(host_rdata), 0);
        @(negedge clk);

        // R2: zero count ignored
        start_op(1'b0, 0);
        #1 chk(!busy, "R2 zero count", int'(busy), 0);
        @(negedge clk);
        // R2: start while busy ignored (direction stays read)
        start_op(1'b0, 2);
        #1 chk(busy, "R2 busy after start", int'(busy), 1);
        @(negedge clk);
        start_op(1'b1, 5);
        #1 chk(fill_ready, "R2 restart ignored", int'(fill_ready), 1);
        @(negedge clk);
        do_reset();

        // R3: fill then visible on rdata
        start_op(1'b0, 1);
        #1 chk(fill_ready, "R3 ready when empty", int'(fill_ready), 1);
        @(negedge clk);
        fill_valid = 1; fill_data = 8'h5A;
        @(negedge clk);
        fill_valid = 0;
        #1;
        chk(host_rdata == 8'h5A, "R3 fill word visible", int'(host_rdata), 'h5A);
        chk(!fill_ready, "R3 not ready when full", int'(fill_ready), 0);
        @(negedge clk);
        host_rd = 1;
        #1 chk(!host_wait, "R5 no wait when full", int'(host_wait), 0);
        @(negedge clk);
        host_rd = 0;
        #1 chk(!busy, "R8 done after one word", int'(busy), 0);
        @(negedge clk);

        // R5: same-cycle refill
        start_op(1'b0, 2);
        fill_valid = 1; fill_data = 8'h11;
        @(negedge clk);
        fill_data = 8'h22; host_rd = 1;
        #1;
        chk(fill_ready, "R5 refill while reading", int'(fill_ready), 1);
        chk(host_rdata == 8'h11, "R5 first word", int'(host_rdata), 'h11);
        @(negedge clk);
        fill_valid = 0;
        #1;
        chk(host_rdata == 8'h22 && !host_wait, "R5 second word", int'(host_rdata), 'h22);
        @(negedge clk);
        host_rd = 0;
        #1 chk(!busy, "R8 done after two", int'(busy), 0);

        // R9: idle strobes ignored
        @(negedge clk);
        host_wr = 1; host_wdata = 8'hEE; host_rd = 1; fill_valid = 1;
        #1;
        chk(!host_wait, "R9 no wait idle", int'(host_wait), 0);
        chk(!fill_ready && !drain_valid, "R9 dma quiet idle", int'({fill_ready, drain_valid}), 0);
        @(negedge clk);
        host_wr = 0; host_rd = 0; fill_valid = 0;
        #1 chk(host_rdata == 8'h22, "R9 latch kept", int'(host_rdata), 'h22);
        @(negedge clk);

        // R6: write lands in drain next cycle
        start_op(1'b1, 1);
        #1 chk(!drain_valid, "R6 empty at start", int'(drain_valid), 0);
        @(negedge clk);
        host_wr = 1; host_wdata = 8'h33;
        #1 chk(!host_wait, "R6 write to empty", int'(host_wait), 0);
        @(negedge clk);
        host_wr = 0;
        #1 chk(drain_valid && drain_data == 8'h33, "R6 drain offered", int'(drain_data), 'h33);
        drain_ready = 1;
        @(negedge clk);
        drain_ready = 0;
        #1 chk(!busy, "R8 write done", int'(busy), 0);
        @(negedge clk);

        // Sweeps
        for (int n = 1; n <= 4; n++)
            for (int d = 0; d <= 2; d++)
                for (int h = 0; h <= 2; h++) begin
                    run_rd(n, d, h, n * 40 + d * 10 + h);
                    run_wr(n, d, h, n * 50 + d * 7 + h + 3);
                end

        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule